// File: doc/BRIEF.md
# Cell-Slot Bandwidth Gate

This block decides, one cell slot at a time, which of four transmit ports may send. It does not arbitrate between them. A shared slot counter, 8 bits wide by default, advances once for every cell that leaves the transmitter and wraps through its full range.

Each port has its own programmed rate. A nonzero rate N opens the port on exactly N+1 of the counter's 256 values. The open values are the counts whose bit-reversed form is at most N, so the permitted slots interleave evenly over the cycle instead of bunching together. A rate of zero closes the port for good, and its FIFO flag is then ignored.

The output marks every port that holds a cell and whose rate window is open at the current count. A downstream arbiter picks one of the marked ports and pulses the cell strobe when that cell is sent. The rate is an upper bound: contention among ports can leave a port with less than its share, and the share holds in full even when every other port is idle.

Top module: `crs_rate_shaper`

## Requirements
- R1: A synchronous active-high reset clears the slot counter to zero. After reset, every port with a nonzero rate and its ready flag set is eligible, because the reversed form of count zero is zero.
- R2: The slot counter advances by one on each clock edge at which `cell_sent` is high. It holds its value on every other edge.
- R3: The slot counter wraps from its maximum value (255) back to 0.
- R4: Over one full cycle of 256 consecutive counts, a port with rate N (N from 1 to 255) and its ready flag held high is eligible on exactly N+1 counts.
- R5: A port with nonzero rate N is eligible at count c exactly when the bit-reversed value of c is at most N. Bit-reversal maps bit 0 to bit 7. Examples: rate 127 opens on the even counts, and rate 63 opens on the counts that are multiples of 4.
- R6: A port whose rate is 0 is never eligible, whatever its ready flag and whatever the count.
- R7: A port whose ready flag is low is never eligible.
- R8: Each port's eligibility depends only on its own rate, its own ready flag and the shared count.
- R9: Eligibility follows changes to a rate or a ready flag within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cell_sent | input | 1 | High for one cycle per transmitted cell; advances the slot counter |
| rate_flat | input | NUM_PORTS*CNT_W | Per-port rates; port p occupies bits [p*CNT_W +: CNT_W] |
| fifo_ready | input | NUM_PORTS | Per-port flag, high when that port's FIFO holds a cell |
| send_ok | output | NUM_PORTS | Per-port eligibility for the current slot |

## Verification
The assertions assume that reset is held for at least one clock edge, and that inputs are settled, non-X values at every edge after reset. They do not assume that rates stay fixed. The hold and alternation properties compare outputs only across cycles in which the bench left the rates and ready flags unchanged. The stimulus drives every input between clock edges. It mixes random rates, flags and strobes with directed full-cycle sweeps, and it changes a rate mid-cycle so that the same-cycle behaviour is covered.

// File: rtl/crs_pkg.sv
package crs_pkg;
    localparam int unsigned CRS_PORTS = 4;
    localparam int unsigned CRS_CNT_W = 8;
    typedef logic [CRS_CNT_W-1:0] slot_t;
endpackage

// File: rtl/crs_slot_counter.sv
module crs_slot_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

    // Modulo counter: the natural overflow supplies the wrap to zero.
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (advance) begin
            count <= count + STEP;
        end
    end
endmodule

// File: rtl/crs_bit_reverse.sv
module crs_bit_reverse #(
    parameter int unsigned CNT_W = 8
) (
    input  logic [CNT_W-1:0] fwd,
    output logic [CNT_W-1:0] rev
);
    for (genvar b = 0; b < CNT_W; b++) begin : g_bit
        assign rev[b] = fwd[CNT_W-1-b];
    end
endmodule

// File: rtl/crs_port_gate.sv
module crs_port_gate #(
    parameter int unsigned CNT_W = 8
) (
    input  logic [CNT_W-1:0] rate,
    input  logic [CNT_W-1:0] spread_slot,
    input  logic             ready,
    output logic             ok
);
    logic rate_live;
    logic in_window;

    always_comb begin
        rate_live = |rate;
        in_window = (spread_slot <= rate);
        ok        = rate_live & in_window & ready;
    end
endmodule

// File: rtl/crs_rate_shaper.sv
module crs_rate_shaper
    import crs_pkg::*;
#(
    parameter int unsigned NUM_PORTS = CRS_PORTS,
    parameter int unsigned CNT_W     = CRS_CNT_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cell_sent,
    input  logic [NUM_PORTS*CNT_W-1:0] rate_flat,
    input  logic [NUM_PORTS-1:0]       fifo_ready,
    output logic [NUM_PORTS-1:0]       send_ok
);
    logic [CNT_W-1:0] slot_count;
    logic [CNT_W-1:0] slot_spread;

    crs_slot_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .advance (cell_sent),
        .count   (slot_count)
    );

    crs_bit_reverse #(.CNT_W(CNT_W)) u_reverse (
        .fwd (slot_count),
        .rev (slot_spread)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        crs_port_gate #(.CNT_W(CNT_W)) u_gate (
            .rate        (rate_flat[p*CNT_W +: CNT_W]),
            .spread_slot (slot_spread),
            .ready       (fifo_ready[p]),
            .ok          (send_ok[p])
        );
    end
endmodule

// File: rtl/crs_rate_shaper_chk.sv
module crs_rate_shaper_chk #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned CNT_W     = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       cell_sent,
    input logic [NUM_PORTS*CNT_W-1:0] rate_flat,
    input logic [NUM_PORTS-1:0]       fifo_ready,
    input logic [NUM_PORTS-1:0]       send_ok
);
    localparam logic [CNT_W-1:0] HALF_RATE = {1'b0, {(CNT_W-1){1'b1}}};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        // R6
        a_r6_zero_rate_closed: assert property (@(posedge clk) disable iff (rst)
            (rate_flat[p*CNT_W +: CNT_W] == '0) |-> !send_ok[p]);

        // R7
        a_r7_needs_ready: assert property (@(posedge clk) disable iff (rst)
            !fifo_ready[p] |-> !send_ok[p]);

        // R1: count is zero right after reset, so any live ready port is open
        a_r1_open_after_reset: assert property (@(posedge clk) disable iff (rst)
            ($past(rst) && fifo_ready[p] && (rate_flat[p*CNT_W +: CNT_W] != '0))
            |-> send_ok[p]);

        // R2: no strobe and unchanged inputs keep the output steady
        a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
            !cell_sent |=> (($stable(rate_flat) && $stable(fifo_ready)) -> $stable(send_ok)));

        // R5: half rate opens on alternate counts
        a_r5_half_rate_alternates: assert property (@(posedge clk) disable iff (rst)
            (cell_sent && fifo_ready[p] && (rate_flat[p*CNT_W +: CNT_W] == HALF_RATE))
            |=> (($stable(rate_flat) && $stable(fifo_ready)) -> (send_ok[p] != $past(send_ok[p]))));
    end
endmodule

bind crs_rate_shaper crs_rate_shaper_chk #(
    .NUM_PORTS (NUM_PORTS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cell_sent  (cell_sent),
    .rate_flat  (rate_flat),
    .fifo_ready (fifo_ready),
    .send_ok    (send_ok)
);

// File: tb/tb_crs_rate_shaper.sv
`timescale 1ns/100ps
module tb_crs_rate_shaper;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cell_sent = 1'b0;
    logic [7:0] rt [4];
    logic [3:0] fifo_ready = 4'b0000;
    logic [31:0] rate_flat;
    logic [3:0] send_ok;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_cnt = 8'd0;

    assign rate_flat = {rt[3], rt[2], rt[1], rt[0]};

    always #2.5 clk = ~clk;

    crs_rate_shaper dut (
        .clk        (clk),
        .rst        (rst),
        .cell_sent  (cell_sent),
        .rate_flat  (rate_flat),
        .fifo_ready (fifo_ready),
        .send_ok    (send_ok)
    );

    function automatic logic [7:0] rev8(logic [7:0] v);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) r[b] = v[7-b];
        return r;
    endfunction

    function automatic logic model_ok(logic [7:0] c, logic [7:0] r, logic rdy);
        return rdy && (r != 8'd0) && (rev8(c) <= r);
    endfunction

    function automatic logic [3:0] model_vec(logic [7:0] c);
        logic [3:0] v;
        for (int p = 0; p < 4; p++) v[p] = model_ok(c, rt[p], fifo_ready[p]);
        return v;
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic check(string req, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: send_ok=%b expected %b (count %0d)", req, got, exp, exp_cnt);
        end
    endtask

    task automatic check_int(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick(logic pulse);
        cell_sent = pulse;
        @(posedge clk);
        #1;
        cell_sent = 1'b0;
        if (pulse && !rst) exp_cnt = exp_cnt + 8'd1;
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        report();
    end

    initial begin
        int tot [4];
        void'($urandom(32'h5EED_0042));
        for (int p = 0; p < 4; p++) rt[p] = 8'd0;
        rst = 1'b1;
        tick(1'b1);
        tick(1'b0);
        rst = 1'b0;
        exp_cnt = 8'd0;
        #1;

        // R6: all rates zero, flags high
        fifo_ready = 4'hF;
        #1;
        check("R6 zero rates after reset", send_ok, 4'b0000);

        // R1: count zero opens every live port
        rt[0] = 8'd1; rt[1] = 8'd2; rt[2] = 8'd3; rt[3] = 8'd4;
        #1;
        check("R1 reset count zero", send_ok, 4'b1111);

        // R2: holding without strobe
        for (int k = 0; k < 3; k++) tick(1'b0);
        check("R2 hold without strobe", send_ok, 4'b1111);
        tick(1'b1);
        check("R2 advance to count 1", send_ok, model_vec(exp_cnt));
        check("R2 count 1 closes low rates", send_ok, 4'b0000);

        // R4 / R5: full sweep
        rt[0] = 8'd63; rt[1] = 8'd127; rt[2] = 8'd0; rt[3] = 8'd200;
        fifo_ready = 4'hF;
        for (int p = 0; p < 4; p++) tot[p] = 0;
        for (int k = 0; k < 256; k++) begin
            #1;
            check("R5 bit-reversed window", send_ok, model_vec(exp_cnt));
            checks++;
            if (send_ok[0] !== (exp_cnt[1:0] == 2'b00)) begin
                fails++;
                $display("FAIL R5 rate 63 every fourth count: got %b expected %b at count %0d",
                         send_ok[0], (exp_cnt[1:0] == 2'b00), exp_cnt);
            end
            for (int p = 0; p < 4; p++) if (send_ok[p]) tot[p]++;
            tick(1'b1);
        end
        check_int("R4 rate 63 slots", tot[0], 64);
        check_int("R4 rate 127 slots", tot[1], 128);
        check_int("R6 rate 0 slots", tot[2], 0);
        check_int("R4 rate 200 slots", tot[3], 201);

        // R3: wrap from 255 to 0
        rt[3] = 8'd1;
        while (exp_cnt != 8'd255) tick(1'b1);
        #1;
        check("R3 count 255 closed for rate 1", send_ok & 4'b1000, 4'b0000);
        tick(1'b1);
        #1;
        check("R3 wrapped to count 0", send_ok & 4'b1000, 4'b1000);

        // R7: flags low close full-rate ports
        for (int p = 0; p < 4; p++) rt[p] = 8'd255;
        fifo_ready = 4'b0000;
        #1;
        check("R7 flags low", send_ok, 4'b0000);
        fifo_ready = 4'b0101;
        #1;
        check("R7 partial flags", send_ok, 4'b0101);

        // R9: same-cycle response to a rate change
        tick(1'b1);
        fifo_ready = 4'hF;
        rt[2] = 8'd0;
        #1;
        check("R9 rate drop seen at once", send_ok, 4'b1011);
        rt[2] = 8'd255;
        #1;
        check("R9 rate raise seen at once", send_ok, 4'b1111);

        // R8: random mix
        for (int k = 0; k < 3000; k++) begin
            for (int p = 0; p < 4; p++) begin
                logic [2:0] pick;
                pick  = 3'($urandom_range(0, 7));
                rt[p] = (pick == 3'd0) ? 8'd0 : (pick == 3'd1) ? 8'd255 : 8'($urandom_range(0, 255));
            end
            fifo_ready = 4'($urandom_range(0, 15));
            #1;
            check("R8 independent ports", send_ok, model_vec(exp_cnt));
            tick(1'($urandom_range(0, 1)));
            #1;
            check("R2 random strobe", send_ok, model_vec(exp_cnt));
        end

        // R1: reset mid-run returns count to zero
        for (int p = 0; p < 4; p++) rt[p] = 8'd1;
        fifo_ready = 4'hF;
        rst = 1'b1;
        tick(1'b1);
        rst = 1'b0;
        exp_cnt = 8'd0;
        #1;
        check("R1 reset mid-run", send_ok, 4'b1111);

        report();
    end
endmodule